// File: doc/BRIEF.md
# Reader Power Mode Controller

This block sequences the low-power states of a contactless reader core. An asynchronous power-down pin forces a hard shutdown. The shutdown drops the regulator and oscillator enables, clamps the digital inputs and floats the output pads, and it does so without waiting for a clock. A register-driven standby bit selects a lighter sleep. In standby the oscillator is stopped and the outputs hold their levels, while the inputs stay live and the retained state stays powered.

Leaving either sleep runs one shared wake-up phase. The core is declared ready only when three handshake flags are high together: reset done, oscillator stable and boot done. A programmable watchdog flags an oscillator that does not settle. A separate modem-off bit switches the transmitter and receiver off while the core stays fully awake.

The regulators, the crystal oscillator and the boot logic are outside the block. They appear only as the three status inputs.

Top module: `rdr_pwr_ctrl`

## Requirements
- R1: While `pdown_i` is 1, `in_clamp_o` and `out_hiz_o` are 1 and `reg_en_o`, `osc_en_o`, `ready_o`, `tx_en_o` and `rx_en_o` are 0. This takes effect asynchronously, with no clock edge needed.
- R2: `pdown_i` takes priority over every other input. Asserting it during standby or during the wake-up phase puts the block into hard power-down.
- R3: After `pdown_i` falls, the pin passes through a two-stage synchronizer. The pads are released (`in_clamp_o` and `out_hiz_o` go to 0) on the third rising clock edge, and at that edge the wake-up phase begins.
- R4: In the wake-up phase, `ready_o` rises only on an edge where `rst_done_i`, `osc_stable_i` and `boot_done_i` are all sampled at 1. If any one of them is 0, `ready_o` stays 0.
- R5: When `stby_i` is 1 in full operation or in the wake-up phase, the block enters standby at the next edge. In standby `osc_en_o` is 0, `out_hold_o` is 1, `reg_en_o` is 1, `in_clamp_o` and `out_hiz_o` are 0, and `ready_o` is 0.
- R6: Clearing `stby_i` in standby starts the same wake-up phase as in R4, and it needs the same three flags.
- R7: In full operation `tx_en_o` and `rx_en_o` are equal to the inverse of `modem_off_i`, combinationally and with no wake-up phase. In every other state `modem_off_i` has no effect and both enables are 0.
- R8: In the wake-up phase, `osc_err_o` goes to 1 on the (`osc_lim_i`+1)th edge while `osc_stable_i` stays 0. It returns to 0 on the edge where `osc_stable_i` is sampled at 1, or when the wake-up phase ends.
- R9: While `rst_ni` is 0 and `pdown_i` is 0, the block is in the wake-up phase. In that phase `reg_en_o` and `osc_en_o` are 1, and `ready_o`, `out_hold_o`, `in_clamp_o` and `osc_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pdown_i | input | 1 | Asynchronous hard power-down pin |
| stby_i | input | 1 | Standby control bit |
| modem_off_i | input | 1 | Radio-off control bit |
| rst_done_i | input | 1 | Internal reset sequence finished |
| osc_stable_i | input | 1 | Oscillator reports stable |
| boot_done_i | input | 1 | Boot sequence finished |
| osc_lim_i | input | TW | Oscillator settle limit in cycles |
| reg_en_o | output | 1 | Regulator enable |
| osc_en_o | output | 1 | Oscillator enable |
| in_clamp_o | output | 1 | Disconnect and clamp digital inputs |
| out_hiz_o | output | 1 | Tristate output pads |
| out_hold_o | output | 1 | Freeze output pad levels |
| tx_en_o | output | 1 | Antenna transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| ready_o | output | 1 | Full operation |
| osc_err_o | output | 1 | Oscillator settle timeout |

## Verification
The assertions check, on every cycle, the rules that tie outputs to one another. The pin being high implies clamped pads. A rise of ready implies that all three flags were sampled high. A radio enable implies ready. The hold control excludes the oscillator enable. The synchronizer releases only after the pin has been low. The settle counter never passes its limit.

The exact edge counts need the bench's directed scenarios. These include the three-edge pad release and the standby entry and exit timing. The bench also shows that a missing flag stalls the wake-up phase, that the error appears after `osc_lim_i`+1 cycles, and that power-down overrides standby.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    PM_WAKE = 2'd0,
    PM_FULL = 2'd1,
    PM_STBY = 2'd2,
    PM_OFF  = 2'd3
  } pm_state_e;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pd_o
);
  logic [STAGES-1:0] sync_q;

  // pin high sets every stage at once; release walks through the chain
  always_ff @(posedge clk_i or negedge rst_ni or posedge pin_i) begin
    if (pin_i)        sync_q <= '1;
    else if (!rst_ni) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b0};
  end

  assign pd_o = sync_q[STAGES-1];

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> $past(!pin_i));
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          stable_i,
  input  logic [TW-1:0] lim_i,
  output logic          err_o
);
  logic [TW-1:0] cnt_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (!active_i) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (stable_i) begin
      err_q <= 1'b0;
    end else if (cnt_q != lim_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $stable(lim_i)) |=> (cnt_q <= lim_i) || !$stable(lim_i));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_i,
  input  logic      stby_i,
  input  logic      all_done_i,
  output pm_state_e st_o
);
  pm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (pd_i) st_d = PM_OFF;
    else begin
      unique case (st_q)
        PM_OFF:  st_d = PM_WAKE;
        PM_WAKE: if (stby_i) st_d = PM_STBY;
                 else if (all_done_i) st_d = PM_FULL;
        PM_FULL: if (stby_i) st_d = PM_STBY;
        PM_STBY: if (!stby_i) st_d = PM_WAKE;
        default: st_d = PM_WAKE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PM_WAKE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  p_pd_priority_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (st_q == PM_OFF));
endmodule

// File: rtl/rdr_pwr_ctrl.sv
module rdr_pwr_ctrl
  import pwr_pkg::*;
#(
  parameter int TW       = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pdown_i,
  input  logic          stby_i,
  input  logic          modem_off_i,
  input  logic          rst_done_i,
  input  logic          osc_stable_i,
  input  logic          boot_done_i,
  input  logic [TW-1:0] osc_lim_i,
  output logic          reg_en_o,
  output logic          osc_en_o,
  output logic          in_clamp_o,
  output logic          out_hiz_o,
  output logic          out_hold_o,
  output logic          tx_en_o,
  output logic          rx_en_o,
  output logic          ready_o,
  output logic          osc_err_o
);
  logic      pd_q;
  logic      hard;
  logic      all_done;
  pm_state_e st;

  pwr_pin_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pdown_i),
    .pd_o   (pd_q)
  );

  assign all_done = rst_done_i & osc_stable_i & boot_done_i;

  pwr_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_i       (pd_q),
    .stby_i     (stby_i),
    .all_done_i (all_done),
    .st_o       (st)
  );

  pwr_osc_timer #(.TW(TW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (st == PM_WAKE && !pd_q),
    .stable_i (osc_stable_i),
    .lim_i    (osc_lim_i),
    .err_o    (osc_err_o)
  );

  // pd_q is set asynchronously, so pad isolation needs no clock
  assign hard       = pd_q | (st == PM_OFF);
  assign reg_en_o   = !hard;
  assign osc_en_o   = !hard && (st != PM_STBY);
  assign in_clamp_o = hard;
  assign out_hiz_o  = hard;
  assign out_hold_o = !hard && (st == PM_STBY);
  assign ready_o    = !hard && (st == PM_FULL);
  assign tx_en_o    = ready_o && !modem_off_i;
  assign rx_en_o    = ready_o && !modem_off_i;

  p_pin_isolate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i |-> (in_clamp_o && out_hiz_o && !reg_en_o && !ready_o));
  p_wake_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(rst_done_i && osc_stable_i && boot_done_i));
  p_hold_osc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hold_o |-> (!osc_en_o && reg_en_o && !in_clamp_o));
  p_radio_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o || rx_en_o) |-> (ready_o && !modem_off_i));
  p_err_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_err_o |-> !ready_o);
endmodule

// File: tb/rdr_pwr_ctrl_test.sv
`timescale 1ns/1ps
module rdr_pwr_ctrl_test;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pdown = 1'b0, stby = 1'b0, moff = 1'b0;
  logic rdone = 1'b0, ostab = 1'b0, bdone = 1'b0;
  logic [TW-1:0] lim = 8'd5;
  logic reg_en, osc_en, clamp, hiz, hold, tx, rx, ready, err;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rdr_pwr_ctrl #(.TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pdown_i(pdown), .stby_i(stby),
    .modem_off_i(moff), .rst_done_i(rdone), .osc_stable_i(ostab),
    .boot_done_i(bdone), .osc_lim_i(lim), .reg_en_o(reg_en),
    .osc_en_o(osc_en), .in_clamp_o(clamp), .out_hiz_o(hiz),
    .out_hold_o(hold), .tx_en_o(tx), .rx_en_o(rx), .ready_o(ready),
    .osc_err_o(err)
  );

  // {stby, moff, exp_ready, exp_tx, exp_hold, exp_osc}; starts from full operation
  localparam logic [5:0] VEC [8] = '{
    6'b00_1101, 6'b01_1001, 6'b11_0010, 6'b10_0010,
    6'b00_0001, 6'b00_1101, 6'b01_1001, 6'b00_1101
  };

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    #5;
    chk("R9 osc_en", osc_en, 1'b1);
    chk("R9 reg_en", reg_en, 1'b1);
    chk("R9 ready", ready, 1'b0);
    chk("R9 clamp", clamp, 1'b0);
    chk("R9 err", err, 1'b0);
    @(negedge clk); rst_ni = 1'b1;
    tick();

    // R4 wake needs all three flags
    rdone = 1'b1; bdone = 1'b1; ostab = 1'b0; lim = 8'd50;
    tick(); tick();
    chk("R4 missing osc", ready, 1'b0);
    ostab = 1'b1; bdone = 1'b0;
    tick();
    chk("R4 missing boot", ready, 1'b0);
    bdone = 1'b1;
    tick();
    chk("R4 all flags", ready, 1'b1);

    // R5 R6 R7 vector walk
    for (int i = 0; i < 8; i++) begin
      stby = VEC[i][5]; moff = VEC[i][4];
      tick();
      chk("R6 ready vec", ready, VEC[i][3]);
      chk("R7 tx vec", tx, VEC[i][2]);
      chk("R7 rx vec", rx, VEC[i][2]);
      chk("R5 hold vec", hold, VEC[i][1]);
      chk("R5 osc vec", osc_en, VEC[i][0]);
    end

    // R7 combinational gating, no edge
    moff = 1'b1; #0.5;
    chk("R7 comb off", tx, 1'b0);
    moff = 1'b0; #0.5;
    chk("R7 comb on", tx, 1'b1);

    // R1 async entry, mid-cycle
    @(negedge clk); pdown = 1'b1; #0.2;
    chk("R1 clamp", clamp, 1'b1);
    chk("R1 hiz", hiz, 1'b1);
    chk("R1 reg_en", reg_en, 1'b0);
    chk("R1 osc_en", osc_en, 1'b0);
    chk("R1 tx", tx, 1'b0);
    chk("R1 ready", ready, 1'b0);

    // R3 release after synchronizer
    tick(); tick();
    pdown = 1'b0;
    tick();
    chk("R3 edge1 clamp", clamp, 1'b1);
    tick();
    chk("R3 edge2 hiz", hiz, 1'b1);
    tick();
    chk("R3 edge3 clamp", clamp, 1'b0);
    chk("R3 edge3 ready", ready, 1'b0);
    tick();
    chk("R3 edge4 ready", ready, 1'b1);

    // R2 pin overrides standby
    stby = 1'b1;
    tick();
    chk("R2 in stby", hold, 1'b1);
    pdown = 1'b1; #0.2;
    chk("R2 hold off", hold, 1'b0);
    chk("R2 hiz", hiz, 1'b1);
    stby = 1'b0;
    tick(); tick();
    pdown = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R2 back to full", ready, 1'b1);

    // R8 oscillator timeout, limit 5
    lim = 8'd5;
    stby = 1'b1; tick();
    stby = 1'b0; ostab = 1'b0; tick();
    repeat (5) tick();
    chk("R8 before limit", err, 1'b0);
    tick();
    chk("R8 at limit", err, 1'b1);
    chk("R8 not ready", ready, 1'b0);
    ostab = 1'b1; tick();
    chk("R8 cleared", err, 1'b0);
    chk("R8 ready", ready, 1'b1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule